// File: doc/BRIEF.md
# Preset-Reload Programmable Frequency Divider

This block divides a stream of input ticks by any integer `x` from 1 up to 2^W. It is built from `STAGES` cascaded 4-bit loadable up-counters. The count register is W = 4·STAGES bits wide. Each nibble advances only when the tick reaches it through the carries of all lower nibbles. The chain never decodes an arbitrary end value. It always ends its period at all-ones and then loads a start value on the same clock edge. That start value is `2^W − x`.

The caller derives the start value with the package helper `div_preset(x, stages)`. It applies that value on `preset_val` and holds it there. The start value is captured at two moments only: a synchronous reset and a wrap from all-ones. `tc_pulse` marks the last tick of each divided period. `count_out` shows the running position. Its bit 0 is the least significant bit, and nibble k sits in bits 4k+3..4k.

Top module: `nibble_chain_divider`

## Requirements
- R1: The count is a W = 4·STAGES bit value. Nibble k (bits 4k+3..4k) advances on a tick only when every nibble below it is 4'hF. The whole chain therefore behaves as one binary up-counter, with carries crossing nibble boundaries (for example, 0x0F followed by 0x10).
- R2: On a clock edge where `tick_in` is 1 and `count_out` is not all-ones, `count_out` becomes the old value plus one.
- R3: On a clock edge where `tick_in` is 1 and `count_out` is all-ones, `count_out` becomes the value on `preset_val` at that edge. No extra state is inserted between all-ones and the reload.
- R4: `tc_pulse` is combinationally 1 exactly when `tick_in` is 1, `count_out` is all-ones and `rst` is 0. Otherwise it is 0.
- R5: While `tick_in` is 0, `count_out` holds its value and `tc_pulse` is 0.
- R6: A clock edge with `rst` = 1 loads `count_out` with `preset_val`, not with zero. While `rst` is 1, `tc_pulse` is 0.
- R7: Starting from a load of preset p, exactly 2^W − p ticks are needed to reach the first `tc_pulse`, counting the tick on which it fires. A preset of 0 gives 2^W ticks. A preset of all-ones gives 1 tick.
- R8: `preset_val` has no effect except on reset edges and reload edges. Changing it mid-period leaves the count sequence unchanged.
- R9: `div_preset(x, s)` returns 2^(4s) − x. For example, x = 40000 with s = 4 gives 0x63C0, and x = 15680 gives 0xC2C0. `div_stages(x)` returns ceil(ceil(log2 x)/4), with a minimum of 1 (40000 gives 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the preset |
| tick_in | input | 1 | Input tick to be divided |
| preset_val | input | W | Start value 2^W − x |
| tc_pulse | output | 1 | One per divided period, on the final tick |
| count_out | output | W | Current chain value |

## Verification
`tc_pulse` is combinational and is due in the same cycle as the tick that sees all-ones. `count_out` is registered and shows the result of a tick one edge later. The bench drives inputs 1 ns after a rising edge and compares both outputs 1 ns after that. The expected count for that cycle comes from all ticks of earlier edges. It then advances its arithmetic model across the next edge. A reset needs one edge before the preset appears, and it is checked after two reset edges.

// File: rtl/divider_pkg.sv
package divider_pkg;

    localparam int NIB_W = 4;

    typedef logic [NIB_W-1:0] nibble_t;

    typedef struct packed {
        nibble_t value;
        logic    carry;
    } stage_io_t;

    // Number of 4-bit stages needed to divide by x.
    function automatic int div_stages(input int unsigned x);
        int n;
        int m;
        n = $clog2(x);
        m = (n + NIB_W - 1) / NIB_W;
        if (m < 1) m = 1;
        return m;
    endfunction

    // Start value for a chain of s stages that yields a period of x ticks.
    function automatic logic [63:0] div_preset(input int unsigned x, input int s);
        logic [63:0] full;
        full = 64'd1 << (NIB_W * s);
        return full - 64'(x);
    endfunction

endpackage

// File: rtl/nibble_stage.sv
module nibble_stage
    import divider_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  nibble_t load_val,
    input  logic    en_in,
    output nibble_t value,
    output logic    cy_out
);

    nibble_t value_q;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            value_q <= load_val;
        end else if (en_in) begin
            value_q <= value_q + 1'b1;
        end
    end

    assign value  = value_q;
    assign cy_out = en_in & (&value_q);

    // A stage without an enable keeps its value.
    assert_stage_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!en_in && !load) |=> $stable(value));

    // A full nibble wraps to zero when enabled and not loaded.
    assert_stage_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (en_in && value == 4'hF && !load) |=> (value == 4'h0));

endmodule

// File: rtl/nibble_chain.sv
module nibble_chain
    import divider_pkg::*;
#(
    parameter int STAGES = 4,
    localparam int W = STAGES * NIB_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] preset,
    output logic [W-1:0] count,
    output logic         full
);

    stage_io_t       st [STAGES];
    logic [STAGES:0] carry;

    assign carry[0] = tick;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        nibble_stage u_stage (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .load_val (preset[k*NIB_W +: NIB_W]),
            .en_in    (carry[k]),
            .value    (st[k].value),
            .cy_out   (st[k].carry)
        );
        assign carry[k+1]              = st[k].carry;
        assign count[k*NIB_W +: NIB_W] = st[k].value;
    end

    assign full = carry[STAGES];

    // Terminal tick reloads the whole chain from the preset.
    assert_chain_reload_R3: assert property (@(posedge clk) disable iff (rst)
        full |=> (count == $past(preset)));

endmodule

// File: rtl/reload_ctl.sv
module reload_ctl (
    input  logic rst,
    input  logic chain_full,
    output logic load,
    output logic tc
);

    assign load = rst | chain_full;
    assign tc   = chain_full & ~rst;

endmodule

// File: rtl/nibble_chain_divider.sv
module nibble_chain_divider
    import divider_pkg::*;
#(
    parameter int STAGES = 4,
    localparam int W = STAGES * NIB_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_in,
    input  logic [W-1:0] preset_val,
    output logic         tc_pulse,
    output logic [W-1:0] count_out
);

    logic chain_full;
    logic do_load;

    nibble_chain #(.STAGES(STAGES)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_in),
        .load   (do_load),
        .preset (preset_val),
        .count  (count_out),
        .full   (chain_full)
    );

    reload_ctl u_ctl (
        .rst        (rst),
        .chain_full (chain_full),
        .load       (do_load),
        .tc         (tc_pulse)
    );

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_in && count_out != {W{1'b1}}) |=> (count_out == W'($past(count_out) + 1'b1)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !tick_in |=> $stable(count_out));

    assert_tc_single_R4: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |=> (!tc_pulse || $past(preset_val) == {W{1'b1}}));

    assert_tc_needs_tick_R4: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |-> (tick_in && count_out == {W{1'b1}}));

endmodule

// File: tb/nibble_chain_divider_bench.sv
`timescale 1ns/1ps
module nibble_chain_divider_bench;
    import divider_pkg::*;

    localparam int ST = 2;
    localparam int BW = ST * 4;
    localparam int FULL = 1 << BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_in = 1'b0;
    logic [BW-1:0] preset_val = '0;
    logic          tc_pulse;
    logic [BW-1:0] count_out;

    int vectors = 0;
    int misses  = 0;
    int exp_cnt;
    logic [BW-1:0] cur_p;
    logic [15:0]   lfsr = 16'hACE1;
    bit done = 0;

    always #2.5 clk = ~clk;

    nibble_chain_divider #(.STAGES(ST)) u_nibble_chain_divider (
        .clk(clk), .rst(rst), .tick_in(tick_in), .preset_val(preset_val),
        .tc_pulse(tc_pulse), .count_out(count_out)
    );

    task automatic check(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle: drive, compare, cross the edge, advance the model.
    task automatic step(input logic tk, input logic [BW-1:0] pv);
        tick_in = tk;
        preset_val = pv;
        #1;
        check("R1 R2 R3 R8 count", count_out, exp_cnt);
        check((tk ? "R4 tc" : "R5 tc idle"), tc_pulse, (tk && exp_cnt == FULL-1));
        @(posedge clk);
        #1;
        if (tk) exp_cnt = (exp_cnt == FULL-1) ? int'(cur_p) : exp_cnt + 1;
    endtask

    task automatic do_reset(input logic [BW-1:0] p);
        rst = 1'b1;
        preset_val = p;
        tick_in = 1'b1;
        #1;
        check("R6 tc in reset", tc_pulse, 0);
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R6 reset load", count_out, p);
        rst = 1'b0;
        exp_cnt = int'(p);
    endtask

    initial begin
        @(posedge clk); #1;
        // R9 package helper values
        check("R9 preset 40000", div_preset(40000, 4), 64'h63C0);
        check("R9 preset 15680", div_preset(15680, 4), 64'hC2C0);
        check("R9 stages 40000", div_stages(40000), 4);
        check("R9 stages 1", div_stages(1), 1);
        check("R9 stages 256", div_stages(256), 2);

        for (int p = 0; p < FULL; p++) begin
            int need;
            int ticks;
            bit seen;
            cur_p = BW'(p);
            do_reset(cur_p);
            need = FULL - p;
            ticks = 0;
            seen = 0;
            while (ticks < need + 3) begin
                logic tk;
                logic [BW-1:0] pv;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                tk = (p % 2 == 1) ? 1'b1 : (lfsr[0] | lfsr[3]);
                // R8: preset scrambled except on the reload cycle
                pv = (exp_cnt == FULL-1) ? cur_p : (cur_p ^ BW'(8'hA5));
                if (tk) ticks++;
                if (tk && exp_cnt == FULL-1 && !seen) begin
                    seen = 1;
                    check("R7 period", ticks, need);
                end
                step(tk, pv);
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule